// File: doc/BRIEF.md
# Byte-Parity Protected SRAM Wrapper

This block wraps a synchronous single-port RAM of 32-bit words and stores a ninth bit beside every data byte. That bit is even parity: the XOR of the byte's eight bits. Parity is generated on each write and checked on each read. The extra bits are held in their own storage, so all data words remain usable. Byte enables select 8-, 16- or 32-bit accesses. A read takes one cycle and has no wait states.

A read whose checked bytes do not match their stored parity raises three signals in the same cycle that the read data is returned. The first is a bus error response, so a bus front end can refuse the data. The second is a one-cycle non-maskable interrupt pulse. The third is a break output toward the timers, which is driven only once a lock bit has been set. A sticky error flag records the event until software clears it by writing a one. A configuration input turns checking off. Parity is still written while checking is off. A per-byte inversion input on writes plants bad parity so that the error path can be exercised.

Top module: `byte_parity_sram`

## Requirements
- R1: A read request (`req`=1, `we`=0) returns the stored word on `rdata`, with `rvalid`=1, in the clock cycle after the request. A write takes effect at the edge that accepts it, and no access inserts wait states.
- R2: Each stored parity bit is even parity, the XOR of the eight bits of its byte. A byte written with its `par_flip` bit at 0 never causes an error when it is read back.
- R3: Bit `be[i]` selects byte i, which is `wdata`/`rdata` bits 8i+7 down to 8i. A write changes the data and the parity of the enabled bytes only, and every other byte of the word keeps both.
- R4: A read checks only the bytes enabled in its own `be`. If any checked byte mismatches, `bus_err` and `nmi` are both 1 for exactly the one cycle in which `rvalid` is 1, and `rdata` still carries the stored word.
- R5: `err_flag` becomes 1 in the cycle after `bus_err` is 1 and stays 1 until `flag_clr` is 1 at a clock edge. If an error and `flag_clr` meet at the same edge, the flag stays set.
- R6: A pulse on `lock_set` sets `lock_bit`, and only reset clears it (`flag_clr` has no effect on it). While `lock_bit` is 1, `brk_out` equals `bus_err`. While `lock_bit` is 0, `brk_out` stays 0.
- R7: When `chk_en` is 0 at a read request, that read raises no error. Writes still store correct parity while `chk_en` is 0.
- R8: On a write, `par_flip[i]`=1 inverts the parity stored for byte i if `be[i]` is 1. For bytes that are not enabled it has no effect.
- R9: After reset, `rvalid`, `bus_err`, `nmi`, `brk_out`, `err_flag` and `lock_bit` are all 0.
- R10: Every one of the 2^ADDR_W word addresses holds a full 32-bit data word, independently of the parity bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chk_en | input | 1 | Parity checking enable, sampled with each read request |
| lock_set | input | 1 | Sets the break-routing lock bit |
| flag_clr | input | 1 | Write-one-to-clear strobe for the error flag |
| req | input | 1 | Access request |
| we | input | 1 | 1 for a write, 0 for a read |
| addr | input | ADDR_W | Word address |
| be | input | BYTES | Byte enables |
| wdata | input | 8*BYTES | Write data |
| par_flip | input | BYTES | Per-byte parity inversion on writes, used for fault injection |
| rdata | output | 8*BYTES | Read data |
| rvalid | output | 1 | Read data valid |
| bus_err | output | 1 | Bus error response for the current read data |
| nmi | output | 1 | Non-maskable interrupt pulse |
| brk_out | output | 1 | Break output toward timers, gated by the lock bit |
| err_flag | output | 1 | Sticky parity error flag |
| lock_bit | output | 1 | Current value of the lock bit |

## Verification
The assertions assume that `addr` and `be` are stable whenever `req` is 1. They also assume that a read from a location returns data only after that location has been written at least once since power-up, because the array is not reset. The stimulus meets both conditions. A full-word sweep writes every address before any read. The later partial-write and fault-injection phases read only words the sweep has already filled. All inputs change on the falling edge. `chk_en` is held constant across each read, so the value sampled with the request is the one the expected result assumes.

// File: rtl/brp_pkg.sv
package brp_pkg;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic rvalid;
        logic chk;
        logic flag;
        logic lock;
    } brp_flags_t;

endpackage

// File: rtl/brp_par_gen.sv
module brp_par_gen
    import brp_pkg::*;
#(
    parameter int BYTES = 4
) (
    input  logic [BYTES*BYTE_W-1:0] data,
    output logic [BYTES-1:0]        par
);

    // Even parity: one XOR tree per byte lane
    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign par[g] = ^data[g*BYTE_W +: BYTE_W];
    end

endmodule

// File: rtl/brp_array.sv
module brp_array
    import brp_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 4
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [BYTES-1:0]        be,
    input  logic [BYTES*BYTE_W-1:0] wdata,
    input  logic [BYTES-1:0]        wpar,
    output logic [BYTES*BYTE_W-1:0] rdata,
    output logic [BYTES-1:0]        rpar
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int LANE_W = BYTE_W + 1;

    // One 9-bit lane per byte: data plus its own parity, written together
    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (wr_en && be[g]) begin
                lane_mem[addr] <= {wpar[g], wdata[g*BYTE_W +: BYTE_W]};
            end
            if (rd_en) begin
                rd_q <= lane_mem[addr];
            end
        end

        assign rdata[g*BYTE_W +: BYTE_W] = rd_q[BYTE_W-1:0];
        assign rpar[g]                   = rd_q[BYTE_W];
    end

endmodule

// File: rtl/brp_check.sv
module brp_check
    import brp_pkg::*;
#(
    parameter int BYTES = 4
) (
    input  logic                    en,
    input  logic [BYTES-1:0]        lanes,
    input  logic [BYTES*BYTE_W-1:0] word,
    input  logic [BYTES-1:0]        par,
    output logic [BYTES-1:0]        bad
);

    logic [BYTES-1:0] recomputed;

    brp_par_gen #(.BYTES(BYTES)) u_regen (
        .data (word),
        .par  (recomputed)
    );

    always_comb begin
        bad = '0;
        if (en) begin
            bad = (recomputed ^ par) & lanes;
        end
    end

endmodule

// File: rtl/byte_parity_sram.sv
module byte_parity_sram
    import brp_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    chk_en,
    input  logic                    lock_set,
    input  logic                    flag_clr,
    input  logic                    req,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [BYTES-1:0]        be,
    input  logic [BYTES*BYTE_W-1:0] wdata,
    input  logic [BYTES-1:0]        par_flip,
    output logic [BYTES*BYTE_W-1:0] rdata,
    output logic                    rvalid,
    output logic                    bus_err,
    output logic                    nmi,
    output logic                    brk_out,
    output logic                    err_flag,
    output logic                    lock_bit
);

    localparam int DATA_W = BYTES * BYTE_W;

    typedef struct packed {
        brp_flags_t       f;
        logic [BYTES-1:0] rbe;
    } state_t;

    state_t st_d, st_q;

    logic              wr_go, rd_go;
    logic [BYTES-1:0]  gen_par, wr_par, rd_par, bad_lanes;
    logic [DATA_W-1:0] rd_word;
    logic              err_now;

    assign wr_go = req && we;
    assign rd_go = req && !we;

    brp_par_gen #(.BYTES(BYTES)) u_wgen (
        .data (wdata),
        .par  (gen_par)
    );

    assign wr_par = gen_par ^ par_flip;

    brp_array #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_array (
        .clk   (clk),
        .wr_en (wr_go),
        .rd_en (rd_go),
        .addr  (addr),
        .be    (be),
        .wdata (wdata),
        .wpar  (wr_par),
        .rdata (rd_word),
        .rpar  (rd_par)
    );

    brp_check #(.BYTES(BYTES)) u_check (
        .en    (st_q.f.rvalid && st_q.f.chk),
        .lanes (st_q.rbe),
        .word  (rd_word),
        .par   (rd_par),
        .bad   (bad_lanes)
    );

    always_comb begin
        st_d     = st_q;
        err_now  = |bad_lanes;
        st_d.f.rvalid = rd_go;
        if (rd_go) begin
            st_d.f.chk = chk_en;
            st_d.rbe   = be;
        end
        // error set takes priority over a clear at the same edge
        st_d.f.flag = (st_q.f.flag && !flag_clr) || err_now;
        st_d.f.lock = st_q.f.lock || lock_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata    = rd_word;
    assign rvalid   = st_q.f.rvalid;
    assign bus_err  = err_now;
    assign nmi      = err_now;
    assign brk_out  = err_now && st_q.f.lock;
    assign err_flag = st_q.f.flag;
    assign lock_bit = st_q.f.lock;

    // R1: read data is presented the cycle after a read request
    assert_read_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we) |=> rvalid);

    // R2: clean write directly followed by a covered read never errors
    assert_clean_roundtrip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req && we && (par_flip == '0), 2) && $past(req && !we)
         && ($past(addr) == $past(addr, 2))
         && (($past(be) & ~$past(be, 2)) == '0)) |-> !bus_err);

    // R5: an error leaves the sticky flag set
    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> err_flag);

    // R5: a clear with no concurrent error empties the flag
    assert_flag_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !bus_err) |=> !err_flag);

    // R6: lock only leaves by reset
    assert_lock_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lock_bit |=> lock_bit);

    // R7: checking disabled at request means no error on the data cycle
    assert_chk_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req && !we && !chk_en) |-> !bus_err);

endmodule

// File: tb/sim_byte_parity_sram.sv
module sim_byte_parity_sram;

    localparam int AW    = 6;
    localparam int NB    = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          chk_en, lock_set, flag_clr, req, we;
    logic [AW-1:0] addr;
    logic [NB-1:0] be, par_flip;
    logic [31:0]   wdata, rdata;
    logic          rvalid, bus_err, nmi, brk_out, err_flag, lock_bit;

    always #5 clk = ~clk;

    byte_parity_sram #(.ADDR_W(AW), .BYTES(NB)) u0 (
        .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .lock_set(lock_set),
        .flag_clr(flag_clr), .req(req), .we(we), .addr(addr), .be(be),
        .wdata(wdata), .par_flip(par_flip), .rdata(rdata), .rvalid(rvalid),
        .bus_err(bus_err), .nmi(nmi), .brk_out(brk_out), .err_flag(err_flag),
        .lock_bit(lock_bit)
    );

    int          n_chk  = 0;
    int          n_fail = 0;
    bit          done   = 0;
    logic [31:0] mdata [DEPTH];
    logic [3:0]  mbad  [DEPTH];
    logic        mflag, mlock;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [3:0] b, input logic [31:0] d,
                      input logic [3:0] f);
        req = 1; we = 1; addr = a[AW-1:0]; be = b; wdata = d; par_flip = f;
        @(negedge clk);
        req = 0; we = 0; par_flip = '0;
        for (int i = 0; i < NB; i++) begin
            if (b[i]) begin
                mdata[a][8*i +: 8] = d[8*i +: 8];
                mbad[a][i]         = f[i];
            end
        end
    endtask

    task automatic rd_chk(input int a, input logic [3:0] b, input string tag);
        logic exp_err;
        exp_err = chk_en && (|(mbad[a] & b));
        req = 1; we = 0; addr = a[AW-1:0]; be = b;
        @(negedge clk);
        req = 0;
        check(rvalid == 1'b1, {tag, " R1 rvalid"}, rvalid, 1);
        check(rdata == mdata[a], {tag, " R1 rdata"}, rdata, mdata[a]);
        check(bus_err == exp_err, {tag, " R4 bus_err"}, bus_err, exp_err);
        check(nmi == exp_err, {tag, " R4 nmi"}, nmi, exp_err);
        check(brk_out == (exp_err && mlock), {tag, " R6 brk_out"}, brk_out,
              exp_err && mlock);
        @(negedge clk);
        check(rvalid == 1'b0, {tag, " R4 single cycle"}, rvalid, 0);
        mflag = mflag | exp_err;
        check(err_flag == mflag, {tag, " R5 flag"}, err_flag, mflag);
        if (mflag) begin
            flag_clr = 1;
            @(negedge clk);
            flag_clr = 0;
            mflag = 0;
            check(err_flag == 1'b0, {tag, " R5 clear"}, err_flag, 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; chk_en = 1; lock_set = 0; flag_clr = 0; req = 0; we = 0;
        addr = '0; be = '0; wdata = '0; par_flip = '0;
        mflag = 0; mlock = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R9: reset state
        check(rvalid == 0, "R9 rvalid", rvalid, 0);
        check(bus_err == 0 && nmi == 0, "R9 err/nmi", {bus_err, nmi}, 0);
        check(brk_out == 0, "R9 brk_out", brk_out, 0);
        check(err_flag == 0, "R9 err_flag", err_flag, 0);
        check(lock_bit == 0, "R9 lock_bit", lock_bit, 0);

        // R10 / R2: fill every word with clean parity, read all back
        for (int a = 0; a < DEPTH; a++) begin
            wr(a, 4'hF, (a * 32'h0101_0101) ^ 32'h5A3C_96E1 ^ (a << 19), 4'h0);
        end
        for (int a = 0; a < DEPTH; a++) begin
            rd_chk(a, 4'hF, "R10 R2 sweep");
        end

        // R3 / R8: every enable pattern with all flip bits set, then every read mask
        for (int b = 0; b < 16; b++) begin
            wr(b, b[3:0], ~mdata[b] ^ (b * 32'h1357_9BDF), 4'hF);
        end
        for (int a = 0; a < 16; a++) begin
            for (int m = 1; m < 16; m++) begin
                rd_chk(a, m[3:0], "R3 R8 R4 mask");
            end
        end

        // R3: rewriting only a bad byte repairs it, others keep their parity
        wr(14, 4'b0010, 32'h0000_7700, 4'h0);
        rd_chk(14, 4'b0010, "R3 repaired byte");
        rd_chk(14, 4'b0100, "R3 untouched bad byte");

        // R5: set wins over a clear at the same edge
        req = 1; we = 0; addr = 15; be = 4'hF;
        @(negedge clk);
        req = 0;
        check(bus_err == 1, "R4 error on bad word", bus_err, 1);
        flag_clr = 1;
        @(negedge clk);
        flag_clr = 0;
        check(err_flag == 1, "R5 set wins over clear", err_flag, 1);
        flag_clr = 1;
        @(negedge clk);
        flag_clr = 0;
        check(err_flag == 0, "R5 clear afterwards", err_flag, 0);

        // R7: checking off hides errors; parity still written while off
        chk_en = 0;
        rd_chk(13, 4'hF, "R7 disabled read");
        wr(13, 4'hF, 32'hC0DE_1234, 4'h0);
        chk_en = 1;
        rd_chk(13, 4'hF, "R7 parity written while off");

        // R6: lock routes the error to the break output
        lock_set = 1;
        @(negedge clk);
        lock_set = 0;
        mlock = 1;
        check(lock_bit == 1, "R6 lock set", lock_bit, 1);
        rd_chk(12, 4'hF, "R6 locked error");
        flag_clr = 1;
        @(negedge clk);
        flag_clr = 0;
        check(lock_bit == 1, "R6 lock survives clear", lock_bit, 1);

        // R6 / R9: only reset clears the lock
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        mlock = 0;
        @(negedge clk);
        check(lock_bit == 0, "R6 R9 lock reset", lock_bit, 0);
        check(err_flag == 0, "R9 flag after reset", err_flag, 0);
        rd_chk(11, 4'hF, "R6 unlocked error no break");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule